// File: doc/BRIEF.md
# Block Coherence Directory with Word Get/Put Port

The block keeps coherence state for a small set of memory blocks shared by a few processor nodes. Each block has one state and one sharer vector. The block also serves a local atomic unit through word-sized reads (get) and writes (put). Processor nodes ask for a block either shared or exclusive, and the directory answers with a grant that carries the block data. Nodes that already hold the block are reached through messages on a single output channel. The channel carries invalidate, recall and word-update messages, each with a destination mask. Nodes answer on a per-node acknowledge vector. A recall acknowledgement also carries the owner's block data.

The atomic unit has its own bit in the sharer vector. It may change one word of a block without taking exclusive ownership. Its writes reach the other holders as word updates, which carry one word, instead of as invalidations. The directory serves one transaction at a time. Any block held in modified state by another node is recalled first and the owner is downgraded to sharer. The backing memory is held inside the block and starts at zero.

Top module: `dsm_word_dir`

## Requirements
- R1: After reset every block is uncached, every memory word reads zero, both request ports are ready, and no message, grant or done is driven.
- R2: A get on a block not held modified by a node completes with `amu_rdata_o` equal to the addressed word in memory and sends no message.
- R3: A get, put or shared read that finds the block modified by another node first sends one recall (`msg_type_o`=2) whose mask is only the owner. The block data acknowledged by the owner is written to memory and used for the response. The owner stays a sharer, so a later invalidate or update includes it.
- R4: A put to a block with no node sharers writes the word to memory, sends no message and raises `amu_done_o` no later than the second cycle after acceptance.
- R5: A put to a block with node sharers writes the word to memory. It sends one update (`msg_type_o`=3) whose mask holds exactly the sharer nodes, with the word index and data. It raises `amu_done_o` only after every targeted node has acknowledged.
- R6: A shared read (`preq_excl_i`=0) returns a one-cycle grant with `pgnt_excl_o`=0 and the current memory block in `pgnt_data_o` (word n at bits n*DW). It sends no message when no other node holds the block modified.
- R7: An exclusive read sends one invalidate (`msg_type_o`=1) to every other node sharer. It grants with `pgnt_excl_o`=1 only after all of them have acknowledged, and the requester becomes the sole node holder.
- R8: While a transaction is in progress both ready outputs are low. When both request ports are valid at an idle cycle, the atomic unit is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| amu_valid_i | input | 1 | Atomic unit request valid |
| amu_ready_o | output | 1 | Atomic unit request accepted this cycle |
| amu_put_i | input | 1 | 1 = put, 0 = get |
| amu_blk_i | input | BW | Block index |
| amu_word_i | input | WW | Word index within block |
| amu_wdata_i | input | DW | Put data |
| amu_done_o | output | 1 | One-cycle completion pulse |
| amu_rdata_o | output | DW | Word value at completion |
| preq_valid_i | input | 1 | Processor request valid |
| preq_ready_o | output | 1 | Processor request accepted this cycle |
| preq_node_i | input | NW | Requesting node |
| preq_excl_i | input | 1 | 1 = exclusive, 0 = shared |
| preq_blk_i | input | BW | Block index |
| pgnt_valid_o | output | 1 | One-cycle grant pulse |
| pgnt_node_o | output | NW | Granted node |
| pgnt_excl_o | output | 1 | Grant is exclusive |
| pgnt_data_o | output | WPB*DW | Block data |
| msg_valid_o | output | 1 | Message valid |
| msg_type_o | output | 2 | 1 invalidate, 2 recall, 3 word update |
| msg_mask_o | output | NODES | Destination nodes, bit n = node n |
| msg_blk_o | output | BW | Block index |
| msg_word_o | output | WW | Word index for updates |
| msg_data_o | output | DW | Word data for updates |
| ack_i | input | NODES | Per-node acknowledge |
| ack_data_i | input | WPB*DW | Block data returned with a recall acknowledgement |

## Verification
The hardest case to reach is a put to a block that a node holds modified. It needs a recall, then an update to the same owner, which is now a sharer, and the done must wait for the second acknowledgement. The bench builds this by first giving a node exclusive ownership and then issuing the put. It checks that the two messages arrive in order and that the memory block merges the recalled data with the new word. The bench's node model acknowledges each message two cycles late, so that a done or grant issued too early is visible.

// File: rtl/dsm_dir_pkg.sv
package dsm_dir_pkg;
  typedef enum logic [1:0] {BLK_INV = 2'd0, BLK_SHR = 2'd1, BLK_MOD = 2'd2} blk_st_e;
  typedef enum logic [1:0] {MSG_NONE = 2'd0, MSG_INV = 2'd1, MSG_RCL = 2'd2, MSG_UPD = 2'd3} msg_e;
  typedef enum logic [1:0] {OP_RD, OP_RDX, OP_GET, OP_PUT} op_e;
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_RCL, S_WAIT, S_DONE} fsm_e;
endpackage

// File: rtl/dsm_word_mem.sv
module dsm_word_mem #(
  parameter int NBLK = 4,
  parameter int WPB  = 2,
  parameter int DW   = 16,
  localparam int BW   = $clog2(NBLK),
  localparam int WW   = $clog2(WPB),
  localparam int BLKW = WPB * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BW-1:0]   blk_i,
  input  logic [WW-1:0]   word_i,
  input  logic            wword_en_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wblk_en_i,
  input  logic [BLKW-1:0] bdata_i,
  output logic [BLKW-1:0] rdata_o
);
  logic [BLKW-1:0] mem_q [NBLK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBLK; i++) mem_q[i] <= '0;
    end else if (wblk_en_i) begin
      mem_q[blk_i] <= bdata_i;
    end else if (wword_en_i) begin
      mem_q[blk_i][word_i*DW +: DW] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[blk_i];
endmodule

// File: rtl/dsm_dir_table.sv
module dsm_dir_table
  import dsm_dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NBLK  = 4,
  localparam int BW   = $clog2(NBLK),
  localparam int SW   = NODES + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] blk_i,
  input  logic          we_i,
  input  blk_st_e       st_i,
  input  logic [SW-1:0] shr_i,
  output blk_st_e       st_o,
  output logic [SW-1:0] shr_o
);
  blk_st_e       st_q  [NBLK];
  logic [SW-1:0] shr_q [NBLK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i]  <= BLK_INV;
        shr_q[i] <= '0;
      end
    end else if (we_i) begin
      st_q[blk_i]  <= st_i;
      shr_q[blk_i] <= shr_i;
    end
  end

  assign st_o  = st_q[blk_i];
  assign shr_o = shr_q[blk_i];

  // R7
  mod_single_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && st_i == BLK_MOD |=> $countones(shr_o) == 1);
endmodule

// File: rtl/dsm_ack_tracker.sv
module dsm_ack_tracker #(
  parameter int NODES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NODES-1:0] mask_i,
  input  logic [NODES-1:0] ack_i,
  output logic [NODES-1:0] pend_o,
  output logic             clear_o
);
  logic [NODES-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (load_i) pend_q <= mask_i;
    else             pend_q <= pend_q & ~ack_i;
  end

  assign pend_o  = pend_q;
  assign clear_o = (pend_q == '0);

  // R5
  no_new_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (pend_o & ~$past(pend_o)) == '0);
endmodule

// File: rtl/dsm_word_dir.sv
module dsm_word_dir
  import dsm_dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NBLK  = 4,
  parameter int WPB   = 2,
  parameter int DW    = 16,
  localparam int NW   = $clog2(NODES),
  localparam int BW   = $clog2(NBLK),
  localparam int WW   = $clog2(WPB),
  localparam int BLKW = WPB * DW,
  localparam int SW   = NODES + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             amu_valid_i,
  output logic             amu_ready_o,
  input  logic             amu_put_i,
  input  logic [BW-1:0]    amu_blk_i,
  input  logic [WW-1:0]    amu_word_i,
  input  logic [DW-1:0]    amu_wdata_i,
  output logic             amu_done_o,
  output logic [DW-1:0]    amu_rdata_o,
  input  logic             preq_valid_i,
  output logic             preq_ready_o,
  input  logic [NW-1:0]    preq_node_i,
  input  logic             preq_excl_i,
  input  logic [BW-1:0]    preq_blk_i,
  output logic             pgnt_valid_o,
  output logic [NW-1:0]    pgnt_node_o,
  output logic             pgnt_excl_o,
  output logic [BLKW-1:0]  pgnt_data_o,
  output logic             msg_valid_o,
  output logic [1:0]       msg_type_o,
  output logic [NODES-1:0] msg_mask_o,
  output logic [BW-1:0]    msg_blk_o,
  output logic [WW-1:0]    msg_word_o,
  output logic [DW-1:0]    msg_data_o,
  input  logic [NODES-1:0] ack_i,
  input  logic [BLKW-1:0]  ack_data_i
);
  localparam logic [SW-1:0] AMU_BIT = {1'b1, {NODES{1'b0}}};

  fsm_e            fsm_q, fsm_d;
  op_e             op_q;
  logic [NW-1:0]   node_q;
  logic [BW-1:0]   blk_q;
  logic [WW-1:0]   word_q;
  logic [DW-1:0]   wdata_q;

  blk_st_e         cur_st, dir_st;
  logic [SW-1:0]   cur_shr, dir_shr;
  logic            dir_we;
  logic [NODES-1:0] node_shr, req_oh, others;
  logic            is_proc, need_rcl;
  logic            mem_ww, mem_bw;
  logic [BLKW-1:0] mem_blk;
  logic            trk_load, trk_clear;
  logic [NODES-1:0] trk_pend;
  logic            msg_vld;
  msg_e            msg_typ;
  logic [NODES-1:0] msg_msk;

  assign is_proc  = (op_q == OP_RD) || (op_q == OP_RDX);
  assign req_oh   = is_proc ? (NODES'(1) << node_q) : '0;
  assign node_shr = cur_shr[NODES-1:0];
  assign others   = node_shr & ~req_oh;
  assign need_rcl = (cur_st == BLK_MOD) && (others != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= S_IDLE;
      op_q    <= OP_RD;
      node_q  <= '0;
      blk_q   <= '0;
      word_q  <= '0;
      wdata_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (fsm_q == S_IDLE) begin
        // atomic unit wins when both are valid
        if (amu_valid_i) begin
          op_q    <= amu_put_i ? OP_PUT : OP_GET;
          blk_q   <= amu_blk_i;
          word_q  <= amu_word_i;
          wdata_q <= amu_wdata_i;
        end else if (preq_valid_i) begin
          op_q   <= preq_excl_i ? OP_RDX : OP_RD;
          node_q <= preq_node_i;
          blk_q  <= preq_blk_i;
        end
      end
    end
  end

  always_comb begin
    fsm_d    = fsm_q;
    msg_vld  = 1'b0;
    msg_typ  = MSG_NONE;
    msg_msk  = '0;
    trk_load = 1'b0;
    mem_ww   = 1'b0;
    mem_bw   = 1'b0;
    dir_we   = 1'b0;
    dir_st   = cur_st;
    dir_shr  = cur_shr;
    unique case (fsm_q)
      S_IDLE: if (amu_valid_i || preq_valid_i) fsm_d = S_ISSUE;
      S_ISSUE: begin
        if (need_rcl) begin
          msg_vld = 1'b1;
          msg_typ = MSG_RCL;
          msg_msk = node_shr;
          fsm_d   = S_RCL;
        end else if (op_q == OP_RDX && others != '0) begin
          msg_vld  = 1'b1;
          msg_typ  = MSG_INV;
          msg_msk  = others;
          trk_load = 1'b1;
          fsm_d    = S_WAIT;
        end else if (op_q == OP_PUT) begin
          mem_ww = 1'b1;
          if (node_shr != '0) begin
            msg_vld  = 1'b1;
            msg_typ  = MSG_UPD;
            msg_msk  = node_shr;
            trk_load = 1'b1;
            fsm_d    = S_WAIT;
          end else begin
            fsm_d = S_DONE;
          end
        end else begin
          fsm_d = S_DONE;
        end
      end
      S_RCL: if ((ack_i & node_shr) != '0) begin
        // owner data lands in memory, owner kept as sharer
        mem_bw = 1'b1;
        dir_we = 1'b1;
        dir_st = BLK_SHR;
        fsm_d  = S_ISSUE;
      end
      S_WAIT: if (trk_clear) fsm_d = S_DONE;
      S_DONE: begin
        dir_we = 1'b1;
        unique case (op_q)
          OP_RD:   begin dir_st = BLK_SHR; dir_shr = cur_shr | {1'b0, req_oh}; end
          OP_RDX:  begin dir_st = BLK_MOD; dir_shr = {1'b0, req_oh}; end
          default: begin dir_st = BLK_SHR; dir_shr = cur_shr | AMU_BIT; end
        endcase
        fsm_d = S_IDLE;
      end
      default: fsm_d = S_IDLE;
    endcase
  end

  dsm_dir_table #(.NODES(NODES), .NBLK(NBLK)) u_tbl (
    .clk_i, .rst_ni, .blk_i(blk_q), .we_i(dir_we), .st_i(dir_st), .shr_i(dir_shr),
    .st_o(cur_st), .shr_o(cur_shr)
  );

  dsm_word_mem #(.NBLK(NBLK), .WPB(WPB), .DW(DW)) u_mem (
    .clk_i, .rst_ni, .blk_i(blk_q), .word_i(word_q), .wword_en_i(mem_ww), .wdata_i(wdata_q),
    .wblk_en_i(mem_bw), .bdata_i(ack_data_i), .rdata_o(mem_blk)
  );

  dsm_ack_tracker #(.NODES(NODES)) u_trk (
    .clk_i, .rst_ni, .load_i(trk_load), .mask_i(msg_msk), .ack_i,
    .pend_o(trk_pend), .clear_o(trk_clear)
  );

  assign amu_ready_o  = (fsm_q == S_IDLE);
  assign preq_ready_o = (fsm_q == S_IDLE) && !amu_valid_i;
  assign amu_done_o   = (fsm_q == S_DONE) && !is_proc;
  assign amu_rdata_o  = mem_blk[word_q*DW +: DW];
  assign pgnt_valid_o = (fsm_q == S_DONE) && is_proc;
  assign pgnt_node_o  = node_q;
  assign pgnt_excl_o  = (op_q == OP_RDX);
  assign pgnt_data_o  = mem_blk;
  assign msg_valid_o  = msg_vld;
  assign msg_type_o   = msg_typ;
  assign msg_mask_o   = msg_msk;
  assign msg_blk_o    = blk_q;
  assign msg_word_o   = word_q;
  assign msg_data_o   = wdata_q;

  // R3
  rcl_one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_RCL |-> $countones(msg_mask_o) == 1);
  // R4
  msg_has_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_mask_o != '0);
  // R5
  done_after_acks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amu_done_o || pgnt_valid_o |-> trk_pend == '0);
  // R6
  gnt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgnt_valid_o |=> !pgnt_valid_o);
  // R8
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !amu_ready_o && !preq_ready_o);
endmodule

// File: tb/dsm_word_dir_bench.sv
module dsm_word_dir_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        amu_valid = 0, amu_put = 0;
  logic [1:0]  amu_blk = 0;
  logic        amu_word = 0;
  logic [15:0] amu_wdata = 0;
  logic        amu_ready_o, amu_done_o;
  logic [15:0] amu_rdata_o;
  logic        preq_valid = 0, preq_excl = 0;
  logic [1:0]  preq_node = 0, preq_blk = 0;
  logic        preq_ready_o, pgnt_valid_o, pgnt_excl_o;
  logic [1:0]  pgnt_node_o;
  logic [31:0] pgnt_data_o;
  logic        msg_valid_o;
  logic [1:0]  msg_type_o;
  logic [3:0]  msg_mask_o;
  logic [1:0]  msg_blk_o;
  logic        msg_word_o;
  logic [15:0] msg_data_o;
  logic [3:0]  ack_vld = 0;
  logic [31:0] rcl_data = 0;

  dsm_word_dir u_dsm_word_dir (
    .clk_i, .rst_ni,
    .amu_valid_i(amu_valid), .amu_ready_o, .amu_put_i(amu_put), .amu_blk_i(amu_blk),
    .amu_word_i(amu_word), .amu_wdata_i(amu_wdata), .amu_done_o, .amu_rdata_o,
    .preq_valid_i(preq_valid), .preq_ready_o, .preq_node_i(preq_node), .preq_excl_i(preq_excl),
    .preq_blk_i(preq_blk), .pgnt_valid_o, .pgnt_node_o, .pgnt_excl_o, .pgnt_data_o,
    .msg_valid_o, .msg_type_o, .msg_mask_o, .msg_blk_o, .msg_word_o, .msg_data_o,
    .ack_i(ack_vld), .ack_data_i(rcl_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int msg_n, ack_cyc, done_cyc, lat, ack_dly;
  logic [3:0] pend_ack;
  logic [1:0] m_type [4];
  logic [3:0] m_mask [4];
  logic       m_word;
  logic [15:0] m_data;
  bit busy_rdy;

  function automatic logic [15:0] val(int b, int w);
    return 16'h1000 + 16'(b * 16 + w);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    cyc++;
    ack_vld = '0;
    if (ack_dly > 0) begin
      ack_dly--;
      if (ack_dly == 0) begin ack_vld = pend_ack; ack_cyc = cyc; end
    end
    if (msg_valid_o) begin
      if (msg_n < 4) begin m_type[msg_n] = msg_type_o; m_mask[msg_n] = msg_mask_o; end
      m_word = msg_word_o; m_data = msg_data_o;
      msg_n++;
      pend_ack = msg_mask_o;
      ack_dly = 2;
    end
  endtask

  task automatic op_start();
    msg_n = 0; busy_rdy = 0; ack_cyc = -1;
  endtask

  task automatic amu_op(bit put, int b, int w, logic [15:0] d, output logic [15:0] rd);
    int n;
    op_start();
    amu_valid = 1; amu_put = put; amu_blk = 2'(b); amu_word = 1'(w); amu_wdata = d;
    while (!amu_ready_o) tick();
    tick();
    amu_valid = 0;
    n = 0;
    while (!amu_done_o && n < 100) begin
      if (amu_ready_o || preq_ready_o) busy_rdy = 1;
      tick(); n++;
    end
    lat = n + 1; done_cyc = cyc; rd = amu_rdata_o;
  endtask

  task automatic proc_op(int node, bit excl, int b, output logic [31:0] data, output bit gx);
    int n;
    op_start();
    preq_valid = 1; preq_node = 2'(node); preq_excl = excl; preq_blk = 2'(b);
    while (!preq_ready_o) tick();
    tick();
    preq_valid = 0;
    n = 0;
    while (!pgnt_valid_o && n < 100) begin
      if (amu_ready_o || preq_ready_o) busy_rdy = 1;
      tick(); n++;
    end
    done_cyc = cyc; data = pgnt_data_o; gx = pgnt_excl_o;
    chk(pgnt_node_o == 2'(node), "R6 grant node", pgnt_node_o, node);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [31:0] bd;
    bit gx, got_amu, amu_first;
    ack_dly = 0; pend_ack = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(amu_ready_o == 1, "R1 amu ready", amu_ready_o, 1);
    chk(preq_ready_o == 1, "R1 preq ready", preq_ready_o, 1);
    chk(msg_valid_o == 0, "R1 no msg", msg_valid_o, 0);
    chk(amu_done_o == 0 && pgnt_valid_o == 0, "R1 no done/grant", {amu_done_o, pgnt_valid_o}, 0);

    // R1 R2 zero memory sweep
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 2; w++) begin
        amu_op(0, b, w, 0, rd);
        chk(rd == 0, "R1 R2 get after reset", rd, 0);
        chk(msg_n == 0, "R2 get no msg", msg_n, 0);
      end

    // R4 put with no node sharers, then R2 read back
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 2; w++) begin
        amu_op(1, b, w, val(b, w), rd);
        chk(msg_n == 0, "R4 put no msg", msg_n, 0);
        chk(lat <= 2, "R4 put latency", lat, 2);
        amu_op(0, b, w, 0, rd);
        chk(rd == val(b, w), "R2 get word", rd, val(b, w));
      end

    // R6 shared reads by every node
    for (int n = 0; n < 4; n++) begin
      proc_op(n, 0, 0, bd, gx);
      chk(bd == {val(0, 1), val(0, 0)}, "R6 shared data", bd, {val(0, 1), val(0, 0)});
      chk(gx == 0 && msg_n == 0, "R6 shared no msg", {gx, 4'(msg_n)}, 0);
    end

    // R5 update to all sharers, R8 busy
    amu_op(1, 0, 1, 16'hBEEF, rd);
    chk(msg_n == 1 && m_type[0] == 2'd3, "R5 one update", {4'(msg_n), m_type[0]}, {4'd1, 2'd3});
    chk(m_mask[0] == 4'b1111, "R5 update mask", m_mask[0], 4'b1111);
    chk(m_word == 1 && m_data == 16'hBEEF, "R5 update word/data", {m_word, m_data}, {1'b1, 16'hBEEF});
    chk(done_cyc > ack_cyc && ack_cyc > 0, "R5 done after acks", done_cyc, ack_cyc + 1);
    chk(busy_rdy == 0, "R8 ready low while busy", busy_rdy, 0);
    proc_op(2, 0, 0, bd, gx);
    chk(bd == {16'hBEEF, val(0, 0)}, "R5 memory updated", bd, {16'hBEEF, val(0, 0)});

    // R7 exclusive read by node1
    proc_op(1, 1, 0, bd, gx);
    chk(msg_n == 1 && m_type[0] == 2'd1, "R7 one invalidate", {4'(msg_n), m_type[0]}, {4'd1, 2'd1});
    chk(m_mask[0] == 4'b1101, "R7 invalidate mask", m_mask[0], 4'b1101);
    chk(gx == 1 && done_cyc > ack_cyc, "R7 excl grant after acks", {gx, 1'b0}, {1'b1, 1'b0});

    // R3 get on modified block
    rcl_data = {16'h2222, 16'h1111};
    amu_op(0, 0, 0, 0, rd);
    chk(msg_n == 1 && m_type[0] == 2'd2 && m_mask[0] == 4'b0010, "R3 recall owner",
        {4'(msg_n), m_type[0], m_mask[0]}, {4'd1, 2'd2, 4'b0010});
    chk(rd == 16'h1111, "R3 recalled word", rd, 16'h1111);
    proc_op(3, 1, 0, bd, gx);
    chk(m_mask[0] == 4'b0010, "R3 owner kept as sharer", m_mask[0], 4'b0010);
    chk(bd == {16'h2222, 16'h1111}, "R3 recalled block", bd, {16'h2222, 16'h1111});

    // R3 R5 put on modified block: recall then update
    rcl_data = {16'h4444, 16'h5555};
    amu_op(1, 0, 0, 16'h3333, rd);
    chk(msg_n == 2 && m_type[0] == 2'd2 && m_type[1] == 2'd3, "R3 R5 recall then update",
        {4'(msg_n), m_type[0], m_type[1]}, {4'd2, 2'd2, 2'd3});
    chk(m_mask[0] == 4'b1000 && m_mask[1] == 4'b1000, "R5 update to old owner",
        {m_mask[0], m_mask[1]}, 8'b10001000);
    chk(done_cyc > ack_cyc, "R5 done after second ack", done_cyc, ack_cyc + 1);
    proc_op(0, 0, 0, bd, gx);
    chk(bd == {16'h4444, 16'h3333}, "R3 R5 merged block", bd, {16'h4444, 16'h3333});

    // R8 priority
    tick();
    amu_valid = 1; amu_put = 0; amu_blk = 1; amu_word = 0;
    preq_valid = 1; preq_node = 2; preq_excl = 1; preq_blk = 1;
    #1;
    chk(amu_ready_o == 1 && preq_ready_o == 0, "R8 amu priority", {amu_ready_o, preq_ready_o}, 2'b10);
    op_start();
    tick();
    amu_valid = 0;
    got_amu = 0; amu_first = 0;
    for (int i = 0; i < 60; i++) begin
      if (amu_done_o) got_amu = 1;
      if (pgnt_valid_o) begin amu_first = got_amu; break; end
      if (preq_valid && preq_ready_o) begin tick(); preq_valid = 0; end
      else tick();
    end
    chk(amu_first == 1, "R8 amu served before proc", amu_first, 1);

    // R3 shared read on block modified by node2
    rcl_data = {16'h7777, 16'h6666};
    proc_op(0, 0, 1, bd, gx);
    chk(msg_n == 1 && m_type[0] == 2'd2 && m_mask[0] == 4'b0100, "R3 proc recall",
        {4'(msg_n), m_type[0], m_mask[0]}, {4'd1, 2'd2, 4'b0100});
    chk(bd == {16'h7777, 16'h6666} && gx == 0, "R3 R6 grant recalled data", bd, {16'h7777, 16'h6666});
    amu_op(1, 1, 1, 16'h0A0A, rd);
    chk(msg_n == 1 && m_mask[0] == 4'b0101, "R5 update mask after recall", m_mask[0], 4'b0101);

    repeat (3) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule